// File: doc/BRIEF.md
# Dual/Cascaded Converter Conversion Sequencer

This block drives an external analog-to-digital converter through a programmed list of channel conversions. Each of sixteen conversion slots holds a 4-bit channel number. The list is written through a small register port, four slots to a 16-bit word. A slot may name any channel, and one channel may appear in several slots. The block can run as two independent 8-slot sequencers with their own triggers and result banks, or as one 16-slot sequencer.

A trigger starts a sequencer at its first slot. The sequencer then requests the converter once per slot until it has completed its programmed count. Only one conversion is outstanding at any time. The block raises a convert-start strobe with the channel number. When the converter's done pulse arrives, it writes the result to the slot's result index. After the last conversion it pulses an end-of-sequence flag and rewinds to the first slot. A trigger that arrives during a run is held as one pending restart.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The channel for slot s is bits [4*(s%4)+3 : 4*(s%4)] of list word s/4, where the word is selected by `cfg_addr_i` on a `cfg_we_i` write. A write is used by every conversion that starts after the write's clock edge.
- R2: In dual mode (`cascade_i`=0), sequencer 1 uses slots and result indices 0..7 and sequencer 2 uses 8..15. Each runs `max_cnt+1` conversions; only the low 3 bits of `max_cnt1_i` count, so the most is 8.
- R3: In cascaded mode (`cascade_i`=1), a single sequencer runs `max_cnt1_i+1` conversions (1 to 16) over slots 0..15 in order, and sequencer 2 never runs.
- R4: In dual mode, sequencer 1 starts on `trig_a_i`, `trig_sw_i` or `trig_ext_i`, and sequencer 2 starts on `trig_b_i` or `trig_sw_i`. In cascaded mode, any of the four starts the single sequencer.
- R5: The done pulse of a sequence's last conversion pulses that sequencer's end-of-sequence output (`eos1_o`, or `eos2_o` for sequencer 2; cascaded mode uses `eos1_o`). The sequencer then stops, and its next run begins at its first slot.
- R6: When both dual-mode sequencers are waiting for the converter, sequencer 1 is served first. It keeps the converter until its sequence ends.
- R7: At most one conversion is outstanding. `res_we_o` pulses together with `conv_done_i`, and `res_idx_o` holds the slot just converted. The next `conv_start_o` comes in the cycle after the done pulse.
- R8: A trigger that arrives while its sequencer is running is kept as one pending request, which restarts the sequence after it ends. Further triggers during that run are ignored.
- R9: A `conv_done_i` pulse while no conversion is outstanding is ignored: no result write, no end-of-sequence pulse, no slot advance.
- R10: Reset (`rst_ni` low) clears the list to channel 0, returns both sequencers to their first slots, drops pending requests and holds all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cascade_i | input | 1 | 1 = one 16-slot sequencer, 0 = two 8-slot sequencers |
| trig_a_i | input | 1 | Trigger strobe A |
| trig_b_i | input | 1 | Trigger strobe B |
| trig_sw_i | input | 1 | Software trigger strobe |
| trig_ext_i | input | 1 | External pin trigger strobe |
| cfg_we_i | input | 1 | Channel list write enable |
| cfg_addr_i | input | 2 | Channel list word select |
| cfg_wdata_i | input | 16 | Channel list word, four 4-bit slots |
| max_cnt1_i | input | 4 | Sequencer 1 (or cascaded) conversion count minus one |
| max_cnt2_i | input | 3 | Sequencer 2 conversion count minus one |
| conv_start_o | output | 1 | Convert-start strobe |
| conv_chan_o | output | 4 | Channel to convert |
| conv_done_i | input | 1 | Converter done pulse |
| res_we_o | output | 1 | Result write strobe |
| res_idx_o | output | 4 | Result slot index |
| eos1_o | output | 1 | End of sequence, sequencer 1 or cascaded |
| eos2_o | output | 1 | End of sequence, sequencer 2 |

## Verification
A software trigger starts both dual-mode sequencers at once. A design with the wrong priority, or one that hands the converter over between conversions, would give an order other than 0,1,8,9,10. Several triggers are sent during a run, and exactly one restart must follow: a design that counts triggers would convert too often, and one that drops them would convert too little. A count of 15 in dual mode must stop at eight slots, and in cascaded mode the same count must reach slot 15. A stray done pulse while the converter is idle must not produce a result write, which a design that fails to check for an outstanding conversion would emit.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  parameter int unsigned CHAN_W_DEF = 4;
  parameter int unsigned SLOT_W_DEF = 4;
  parameter int unsigned REG_W_DEF  = 16;

  typedef enum logic {OWN_S1 = 1'b0, OWN_S2 = 1'b1} owner_e;
endpackage

// File: rtl/adc_chan_table.sv
module adc_chan_table #(
  parameter int unsigned CHAN_W = 4,
  parameter int unsigned NSLOT  = 16,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned NREG   = NSLOT * CHAN_W / REG_W,
  parameter int unsigned AW     = (NREG > 1) ? $clog2(NREG) : 1,
  parameter int unsigned SW     = $clog2(NSLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [SW-1:0]     rd_slot_i,
  output logic [CHAN_W-1:0] rd_chan_o
);
  logic [REG_W-1:0]        regs_q [NREG];
  logic [NSLOT*CHAN_W-1:0] flat;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && addr_i == AW'(g)) regs_q[g] <= wdata_i;
    end
    assign flat[g*REG_W +: REG_W] = regs_q[g];
  end

  // slot s sits at nibble s of the concatenated words
  assign rd_chan_o = flat[rd_slot_i*CHAN_W +: CHAN_W];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(addr_i)] == $past(wdata_i)); // R1
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine #(
  parameter int unsigned SLOT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [SLOT_W-1:0] base_i,
  input  logic [SLOT_W-1:0] last_off_i,
  input  logic              done_i,
  output logic              req_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              eos_o
);
  logic              active_q, pend_q;
  logic [SLOT_W-1:0] off_q;
  logic              is_last;

  assign is_last = (off_q == last_off_i);
  assign req_o   = active_q;
  assign slot_o  = base_i | off_q;
  assign eos_o   = done_i & is_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      off_q    <= '0;
    end else if (done_i) begin
      if (is_last) begin
        off_q    <= '0;
        active_q <= pend_q | trig_i;
        pend_q   <= 1'b0;
      end else begin
        off_q <= off_q + 1'b1;
        if (trig_i) pend_q <= 1'b1;
      end
    end else if (trig_i) begin
      if (active_q) pend_q <= 1'b1;
      else          active_q <= 1'b1;
    end
  end

  AST_OFF_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> off_q <= last_off_i); // R5
  AST_EOS_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |=> off_q == '0); // R5
  AST_DONE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> active_q); // R7
  AST_PEND_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> active_q); // R8
endmodule

// File: rtl/adc_conv_arb.sv
module adc_conv_arb
  import adc_seq_pkg::*;
#(
  parameter int unsigned SLOT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req1_i,
  input  logic              req2_i,
  input  logic [SLOT_W-1:0] slot1_i,
  input  logic [SLOT_W-1:0] slot2_i,
  input  logic              done_i,
  output logic              start_o,
  output logic              done1_o,
  output logic              done2_o,
  output logic [SLOT_W-1:0] cur_slot_o
);
  logic   busy_q;
  owner_e owner_q;
  logic   done_ok;

  assign start_o    = !busy_q && (req1_i || req2_i);
  assign done_ok    = done_i && busy_q;
  assign done1_o    = done_ok && owner_q == OWN_S1;
  assign done2_o    = done_ok && owner_q == OWN_S2;
  // channel held stable for the whole conversion
  assign cur_slot_o = busy_q ? ((owner_q == OWN_S1) ? slot1_i : slot2_i)
                             : (req1_i ? slot1_i : slot2_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= OWN_S1;
    end else if (start_o) begin
      busy_q  <= 1'b1;
      owner_q <= req1_i ? OWN_S1 : OWN_S2;
    end else if (done_ok) begin
      busy_q  <= 1'b0;
    end
  end

  AST_S1_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && req1_i) |=> owner_q == OWN_S1); // R6
  AST_SINGLE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> busy_q && !start_o); // R7
  AST_DONE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_ok |=> !busy_q); // R7
  AST_STRAY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !busy_q) |-> !(done1_o || done2_o)); // R9
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned CHAN_W = CHAN_W_DEF,
  parameter int unsigned SLOT_W = SLOT_W_DEF,
  parameter int unsigned REG_W  = REG_W_DEF,
  localparam int unsigned NSLOT  = 1 << SLOT_W,
  localparam int unsigned NREG   = NSLOT * CHAN_W / REG_W,
  localparam int unsigned REG_AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cascade_i,
  input  logic              trig_a_i,
  input  logic              trig_b_i,
  input  logic              trig_sw_i,
  input  logic              trig_ext_i,
  input  logic              cfg_we_i,
  input  logic [REG_AW-1:0] cfg_addr_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  input  logic [SLOT_W-1:0] max_cnt1_i,
  input  logic [SLOT_W-2:0] max_cnt2_i,
  output logic              conv_start_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  input  logic              conv_done_i,
  output logic              res_we_o,
  output logic [SLOT_W-1:0] res_idx_o,
  output logic              eos1_o,
  output logic              eos2_o
);
  localparam logic [SLOT_W-1:0] BASE2 = SLOT_W'(NSLOT / 2);

  logic              trig1, trig2;
  logic [SLOT_W-1:0] last1, last2;
  logic              req1, req2, done1, done2;
  logic [SLOT_W-1:0] slot1, slot2, cur_slot;

  assign trig1 = trig_a_i | trig_sw_i | trig_ext_i | (cascade_i & trig_b_i);
  assign trig2 = !cascade_i & (trig_b_i | trig_sw_i);
  assign last1 = cascade_i ? max_cnt1_i : {1'b0, max_cnt1_i[SLOT_W-2:0]};
  assign last2 = {1'b0, max_cnt2_i};

  adc_chan_table #(.CHAN_W(CHAN_W), .NSLOT(NSLOT), .REG_W(REG_W)) u_tbl (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .rd_slot_i(cur_slot), .rd_chan_o(conv_chan_o)
  );

  adc_seq_engine #(.SLOT_W(SLOT_W)) u_eng1 (
    .clk_i, .rst_ni, .trig_i(trig1), .base_i('0), .last_off_i(last1),
    .done_i(done1), .req_o(req1), .slot_o(slot1), .eos_o(eos1_o)
  );

  adc_seq_engine #(.SLOT_W(SLOT_W)) u_eng2 (
    .clk_i, .rst_ni, .trig_i(trig2), .base_i(BASE2), .last_off_i(last2),
    .done_i(done2), .req_o(req2), .slot_o(slot2), .eos_o(eos2_o)
  );

  adc_conv_arb #(.SLOT_W(SLOT_W)) u_arb (
    .clk_i, .rst_ni, .req1_i(req1), .req2_i(req2), .slot1_i(slot1),
    .slot2_i(slot2), .done_i(conv_done_i), .start_o(conv_start_o),
    .done1_o(done1), .done2_o(done2), .cur_slot_o(cur_slot)
  );

  assign res_we_o  = done1 | done2;
  assign res_idx_o = cur_slot;

  AST_BANK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done1 && !cascade_i) |-> !res_idx_o[SLOT_W-1]); // R2
  AST_BANK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done2 |-> res_idx_o[SLOT_W-1]); // R2
  AST_CASC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cascade_i |-> !eos2_o); // R3
endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int CLK_P = 10;
  localparam int LAT   = 2;

  logic clk = 1'b0, rst_ni = 1'b0, cascade = 1'b0;
  logic ta = 0, tb = 0, tsw = 0, tex = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0] max1 = '0;
  logic [2:0] max2 = '0;
  logic conv_start, conv_done = 0, res_we, eos1, eos2;
  logic [3:0] conv_chan, res_idx;

  adc_seq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cascade_i(cascade),
    .trig_a_i(ta), .trig_b_i(tb), .trig_sw_i(tsw), .trig_ext_i(tex),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .max_cnt1_i(max1), .max_cnt2_i(max2),
    .conv_start_o(conv_start), .conv_chan_o(conv_chan), .conv_done_i(conv_done),
    .res_we_o(res_we), .res_idx_o(res_idx), .eos1_o(eos1), .eos2_o(eos2)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  int lidx [0:63];
  int lchan [0:63];
  int exp_idx [0:63];
  int nlog = 0, exp_n = 0, neos1 = 0, neos2 = 0, overlap = 0;
  int cyc = 0, last_done_cyc = 0, last_gap = 0, lat_cnt = 0;
  bit spur = 0;
  logic [15:0] tbl [0:3];

  // converter model: drives done at negedge, samples a quarter period later
  always @(negedge clk) begin
    conv_done = (lat_cnt == 1) || spur;
    spur = 0;
    if (lat_cnt > 0) lat_cnt--;
    #(CLK_P/4);
    cyc++;
    if (res_we) begin
      if (nlog < 64) begin lidx[nlog] = res_idx; lchan[nlog] = conv_chan; end
      nlog++;
      last_done_cyc = cyc;
    end
    if (eos1) neos1++;
    if (eos2) neos2++;
    if (conv_start) begin
      if (lat_cnt != 0 || conv_done) overlap++;
      if (nlog > 0) last_gap = cyc - last_done_cyc;
      lat_cnt = LAT;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_chan(input int s);
    return int'((tbl[s/4] >> (4*(s%4))) & 16'hF);
  endfunction

  task automatic clear_log();
    nlog = 0; exp_n = 0; neos1 = 0; neos2 = 0; overlap = 0; last_gap = 0;
  endtask

  task automatic add_exp(input int first, input int cnt);
    for (int i = 0; i < cnt; i++) begin exp_idx[exp_n] = first + i; exp_n++; end
  endtask

  task automatic fire(input bit a, input bit b, input bit s, input bit e);
    @(negedge clk); ta = a; tb = b; tsw = s; tex = e;
    @(negedge clk); ta = 0; tb = 0; tsw = 0; tex = 0;
  endtask

  task automatic wr_reg(input int a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    tbl[a] = d;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_seq(input string req);
    int bad_at = -1;
    chk(nlog == exp_n, req, "conversion count", nlog, exp_n);
    for (int i = 0; i < exp_n && i < nlog; i++)
      if (bad_at < 0 && (lidx[i] != exp_idx[i] || lchan[i] != exp_chan(exp_idx[i]))) bad_at = i;
    if (bad_at >= 0)
      chk(0, req, $sformatf("idx/chan at %0d chan=%0d", bad_at, lchan[bad_at]),
          lidx[bad_at], exp_idx[bad_at]);
    else chk(1, req, "sequence", 0, 0);
    chk(overlap == 0, "R7", "overlapping starts", overlap, 0);
  endtask

  task automatic t_reset();
    idle(3);
    chk(conv_start == 0, "R10", "start in reset", conv_start, 0);
    chk(res_we == 0 && eos1 == 0 && eos2 == 0, "R10", "strobes in reset", res_we, 0);
    @(negedge clk); rst_ni = 1;
    idle(2);
    chk(conv_start == 0, "R10", "start after reset", conv_start, 0);
  endtask

  task automatic t_dual_a();
    cascade = 0; max1 = 4'd3; clear_log();
    fire(1, 0, 0, 0); idle(40);
    add_exp(0, 4); expect_seq("R1 R2");
    chk(neos1 == 1 && neos2 == 0, "R5", "eos1 count", neos1, 1);
    chk(last_gap == 1, "R7", "done-to-start gap", last_gap, 1);
  endtask

  task automatic t_sw_both();
    max1 = 4'd1; max2 = 3'd2; clear_log();
    fire(0, 0, 1, 0); idle(40);
    add_exp(0, 2); add_exp(8, 3); expect_seq("R6 R4");
    chk(neos1 == 1 && neos2 == 1, "R5", "eos both", neos1 + neos2, 2);
  endtask

  task automatic t_b_full();
    max2 = 3'd7; clear_log();
    fire(0, 1, 0, 0); idle(50);
    add_exp(8, 8); expect_seq("R2");
    chk(neos2 == 1 && neos1 == 0, "R5", "eos2 only", neos2, 1);
  endtask

  task automatic t_ext();
    max1 = 4'd0; clear_log();
    fire(0, 0, 0, 1); idle(20);
    add_exp(0, 1); expect_seq("R4");
  endtask

  task automatic t_pending();
    max1 = 4'd2; clear_log();
    fire(1, 0, 0, 0); idle(2);
    fire(1, 0, 0, 0); fire(1, 0, 0, 0);
    idle(50);
    add_exp(0, 3); add_exp(0, 3); expect_seq("R8");
    chk(neos1 == 2, "R8", "eos1 count after pending", neos1, 2);
  endtask

  task automatic t_dual_cap();
    cascade = 0; max1 = 4'hF; clear_log();
    fire(1, 0, 0, 0); idle(50);
    add_exp(0, 8); expect_seq("R2");
  endtask

  task automatic t_cascade();
    cascade = 1; max1 = 4'hF; clear_log();
    fire(0, 1, 0, 0); idle(80);
    add_exp(0, 16); expect_seq("R3 R4");
    chk(neos1 == 1 && neos2 == 0, "R3", "cascade eos", neos2, 0);
    max1 = 4'd4; clear_log();
    fire(0, 0, 1, 0); idle(40);
    add_exp(0, 5); expect_seq("R3");
    cascade = 0;
  endtask

  task automatic t_spur();
    clear_log();
    @(negedge clk); spur = 1;
    idle(5);
    chk(nlog == 0, "R9", "result writes on stray done", nlog, 0);
    chk(neos1 == 0 && neos2 == 0, "R9", "eos on stray done", neos1 + neos2, 0);
    max1 = 4'd1; clear_log();
    fire(1, 0, 0, 0); idle(20);
    add_exp(0, 2); expect_seq("R9");
  endtask

  task automatic t_rewrite();
    wr_reg(1, 16'h6D2E);
    cascade = 0; max1 = 4'd7; clear_log();
    fire(0, 0, 0, 1); idle(50);
    add_exp(0, 8); expect_seq("R1");
  endtask

  task automatic t_reset_mid();
    cascade = 0; max1 = 4'd7; clear_log();
    fire(1, 0, 0, 0); idle(7);
    fire(1, 0, 0, 0);
    @(negedge clk); rst_ni = 0;
    for (int i = 0; i < 4; i++) tbl[i] = '0;
    idle(3);
    @(negedge clk); rst_ni = 1;
    idle(LAT + 3);
    max1 = 4'd1; clear_log();
    fire(1, 0, 0, 0); idle(20);
    add_exp(0, 2); expect_seq("R10");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) tbl[i] = '0;
    t_reset();
    wr_reg(0, 16'h3A5C);
    wr_reg(1, 16'hC0F5);
    wr_reg(2, 16'h1234);
    wr_reg(3, 16'h9E7B);
    t_dual_a();
    t_sw_both();
    t_b_full();
    t_ext();
    t_pending();
    t_dual_cap();
    t_cascade();
    t_spur();
    t_rewrite();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule